// File: doc/BRIEF.md
# Frame-Synced Serial Converter Input Port

This block is the slave end of a three- or four-wire serial link feeding a 12-bit voltage-output converter. It runs entirely on one system clock. The external chip-select, frame-sync, serial-clock and serial-data pins pass through a synchronizer, and their edges are detected on the system clock. Because of this, the system clock must run at least four times faster than the serial clock.

A word starts when frame sync falls while the port is enabled by chip select. Sixteen data bits then arrive MSB first, one on each falling edge of the serial clock. After the sixteenth bit, the first rising edge on either the serial clock or frame sync moves the word into the output latch and raises a one-cycle update strobe. The lower twelve bits of the word form the converter code, which is linear: 0x000 means zero output and 0x800 means mid-scale. The upper four bits are presented as control bits, and they latch together with the code.

With chip select wired permanently low, the port works as a three-wire receiver. When chip select is driven, several ports can share one serial bus.

Top module: `dac_serial_rx`

## Requirements
- R1: Reset clears the code and control outputs to zero and holds the update strobe low.
- R2: While chip select (active low) is high, all serial activity is ignored. No update strobe occurs and the outputs keep their values.
- R3: A frame-sync falling edge while enabled starts a new word. If frame sync falls again before sixteen bits have arrived, the partial word is discarded and counting restarts from the first bit.
- R4: Data is sampled on serial-clock falling edges, MSB first, sixteen bits per word. Word bits 11..0 appear on the code output and bits 15..12 appear on the control output.
- R5: After the sixteenth bit, the first rising edge of the serial clock, or of frame sync, loads the latch. The update strobe is high for exactly one system cycle.
- R6: A serial-clock rising edge before the sixteenth bit has arrived causes no load.
- R7: If chip select rises in the middle of a word, the partial word is discarded. Edges that follow after chip select is re-enabled cannot complete it.
- R8: With chip select held low across consecutive frames (three-wire use), every complete word loads. The same holds when chip select is pulsed low around each frame (four-wire use).
- R9: The update strobe and the new output values appear together on the third system clock edge after the qualifying pin edge. The outputs do not change in any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select, active low, asynchronous |
| fsync_pin | input | 1 | Frame sync, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| sdata_pin | input | 1 | Serial data, asynchronous |
| dac_code | output | 12 | Latched converter code |
| ctrl_bits | output | 4 | Latched upper control bits of the word |
| update_pulse | output | 1 | One-cycle strobe when the latch is loaded |

## Verification
A pin edge takes two synchronizer stages to reach the edge detector. The latch and the strobe register on the following edge, so results are due on the third system clock edge after the qualifying pin edge. The bench drives pins on falling system-clock edges and samples on falling edges. At each trigger it checks that the strobe is still low after the second rising edge, high together with the expected code and control bits after the third, and low again one cycle later. Cases that must not load use the same window, expecting a low strobe and unchanged outputs.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_ARMED = 2'd2
  } rx_state_e;

  localparam int PIN_CS   = 0;
  localparam int PIN_FS   = 1;
  localparam int PIN_SCLK = 2;
  localparam int PIN_SD   = 3;
  localparam int PIN_N    = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int         N       = 4,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_o <= RST_VAL;
    else     prev_o <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import dsr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fs_fall,
  input  logic              fs_rise,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic              sdata,
  output logic              load,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
      sreg    <= '0;
    end else if (!enable) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
    end else if (fs_fall) begin
      state   <= RX_SHIFT;
      bit_cnt <= '0;
    end else begin
      case (state)
        RX_SHIFT: begin
          if (sclk_fall) begin
            sreg <= {sreg[WORD_W-2:0], sdata};
            if (bit_cnt == LAST_BIT) state <= RX_ARMED;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end
        end
        RX_ARMED: begin
          if (sclk_rise || fs_rise) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign load = enable && !fs_fall && (state == RX_ARMED) && (sclk_rise || fs_rise);
  assign word = sreg;

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !load);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && fs_fall) |=> (state == RX_SHIFT && bit_cnt == '0));
endmodule

// File: rtl/code_latch.sv
module code_latch #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [WORD_W-1:0]        word,
  output logic [CODE_W-1:0]        code_o,
  output logic [WORD_W-CODE_W-1:0] ctrl_o,
  output logic                     pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      ctrl_o  <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= load;
      if (load) begin
        code_o <= word[CODE_W-1:0];
        ctrl_o <= word[WORD_W-1:CODE_W];
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (code_o == '0 && ctrl_o == '0 && !pulse_o));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && !$past(rst)) |-> ($stable(code_o) && $stable(ctrl_o)));
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dsr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n_pin,
  input  logic                     fsync_pin,
  input  logic                     sclk_pin,
  input  logic                     sdata_pin,
  output logic [CODE_W-1:0]        dac_code,
  output logic [WORD_W-CODE_W-1:0] ctrl_bits,
  output logic                     update_pulse
);
  localparam logic [PIN_N-1:0] PIN_IDLE = PIN_N'(4'b0111);

  logic [PIN_N-1:0]  pins_raw, pins_s, pins_p;
  logic              fs_fall, fs_rise, sclk_fall, sclk_rise, enable, load;
  logic [WORD_W-1:0] word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n_pin;
    pins_raw[PIN_FS]   = fsync_pin;
    pins_raw[PIN_SCLK] = sclk_pin;
    pins_raw[PIN_SD]   = sdata_pin;
  end

  pin_sync #(
    .N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) i_sync (
    .clk(clk), .rst(rst), .pin_i(pins_raw), .sync_o(pins_s), .prev_o(pins_p)
  );

  assign enable    = !pins_s[PIN_CS];
  assign fs_fall   =  pins_p[PIN_FS]   && !pins_s[PIN_FS];
  assign fs_rise   = !pins_p[PIN_FS]   &&  pins_s[PIN_FS];
  assign sclk_fall =  pins_p[PIN_SCLK] && !pins_s[PIN_SCLK];
  assign sclk_rise = !pins_p[PIN_SCLK] &&  pins_s[PIN_SCLK];

  word_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .enable(enable),
    .fs_fall(fs_fall), .fs_rise(fs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .sdata(pins_s[PIN_SD]), .load(load), .word(word)
  );

  code_latch #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_latch (
    .clk(clk), .rst(rst), .load(load), .word(word),
    .code_o(dac_code), .ctrl_o(ctrl_bits), .pulse_o(update_pulse)
  );
endmodule

// File: tb/test_dac_serial_rx.sv
module test_dac_serial_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b1, sd = 1'b0;
  logic [11:0] code;
  logic [3:0]  ctrl;
  logic        pulse;

  int checks = 0;
  int failures = 0;
  logic [11:0] exp_code = '0;
  logic [3:0]  exp_ctrl = '0;

  always #10 clk = ~clk;

  dac_serial_rx i_dac_serial_rx (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n), .fsync_pin(fs), .sclk_pin(sclk),
    .sdata_pin(sd), .dac_code(code), .ctrl_bits(ctrl), .update_pulse(pulse)
  );

  // {four_wire, trigger_by_fsync, word}
  localparam logic [17:0] VEC [7] = '{
    {1'b0, 1'b0, 16'hA123},
    {1'b0, 1'b0, 16'h0800},
    {1'b0, 1'b1, 16'h5FFF},
    {1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b0, 16'hF001},
    {1'b1, 1'b1, 16'h7ABC},
    {1'b0, 1'b1, 16'hC555}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sd = w[15-i];
      tick(4);
      sclk = 1'b0;
      tick(4);
      if (i != nbits - 1) sclk = 1'b1;
    end
  endtask

  task automatic trigger(input bit by_fs, input bit exp_load, input logic [15:0] w,
                         input string req);
    if (by_fs) fs = 1'b1; else sclk = 1'b1;
    tick(2);
    chk({req, " R9 strobe early"}, 32'(pulse), 32'd0);
    tick(1);
    if (exp_load) begin
      exp_code = w[11:0];
      exp_ctrl = w[15:12];
    end
    chk({req, " R5 strobe"}, 32'(pulse), 32'(exp_load));
    chk({req, " R4 code"}, 32'(code), 32'(exp_code));
    chk({req, " R4 ctrl"}, 32'(ctrl), 32'(exp_ctrl));
    tick(1);
    chk({req, " R5 strobe width"}, 32'(pulse), 32'd0);
  endtask

  task automatic idle_pins(input bit release_cs);
    sclk = 1'b1;
    fs = 1'b1;
    tick(4);
    if (release_cs) cs_n = 1'b1;
    tick(4);
  endtask

  task automatic frame(input logic [15:0] w, input bit four_wire, input bit by_fs,
                       input string req);
    if (four_wire) begin
      cs_n = 1'b0;
      tick(4);
    end
    fs = 1'b0;
    tick(4);
    shift_bits(w, 16);
    trigger(by_fs, 1'b1, w, req);
    idle_pins(four_wire);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 code", 32'(code), 32'd0);
    chk("R1 ctrl", 32'(ctrl), 32'd0);
    chk("R1 strobe", 32'(pulse), 32'd0);

    // R8 three-wire rows keep cs low; four-wire rows pulse it
    cs_n = 1'b0;
    tick(4);
    for (int v = 0; v < 7; v++) begin
      if (VEC[v][17]) begin
        cs_n = 1'b1;
        tick(4);
      end
      frame(VEC[v][15:0], VEC[v][17], VEC[v][16], "R8 vector");
      if (VEC[v][17]) cs_n = 1'b0;
    end

    // R2 chip select high: full word ignored
    cs_n = 1'b1;
    tick(4);
    fs = 1'b0;
    tick(4);
    shift_bits(16'h1234, 16);
    trigger(1'b0, 1'b0, 16'h1234, "R2 disabled");
    idle_pins(1'b0);

    // R6 rising edge after only fifteen bits
    cs_n = 1'b0;
    tick(4);
    fs = 1'b0;
    tick(4);
    shift_bits(16'h2468, 15);
    trigger(1'b0, 1'b0, 16'h2468, "R6 short word");
    idle_pins(1'b0);

    // R3 restart: eight bits, new frame-sync fall, then full word
    fs = 1'b0;
    tick(4);
    shift_bits(16'hFFFF, 8);
    sclk = 1'b1;
    fs = 1'b1;
    tick(4);
    frame(16'h3C3C, 1'b0, 1'b0, "R3 restart");

    // R7 chip select rises mid-word, then remaining bits arrive
    fs = 1'b0;
    tick(4);
    shift_bits(16'h9999, 10);
    cs_n = 1'b1;
    tick(4);
    cs_n = 1'b0;
    tick(4);
    sclk = 1'b1;
    tick(4);
    shift_bits(16'h6600, 6);
    trigger(1'b0, 1'b0, 16'h0, "R7 cs abort");
    idle_pins(1'b0);

    // R1 reset after activity clears the latch
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    exp_code = '0;
    exp_ctrl = '0;
    chk("R1 code after reset", 32'(code), 32'd0);
    chk("R1 ctrl after reset", 32'(ctrl), 32'd0);

    finish_run();
  end
endmodule